// File: doc/BRIEF.md
# Quadrature Position Counter

This block turns the two phase signals of an incremental rotary encoder into a bounded position count. Both phase inputs must already be synchronised to the block clock. The block compares the phase pair it sees now with the pair it saw on the previous clock. From that comparison it finds the counted edges and the direction of rotation. It then steps a position register held between a programmable floor and a programmable ceiling.

At a limit the counter either rolls over or holds. In wrap mode it rolls over and reports the event. In clamp mode it pins the count at the limit, which suits a control knob or an end-stopped axis. Five sticky flags record events for firmware:

- overflow
- underflow
- compare hit
- reversal
- phase error

A per-flag enable mask folds the five flags into a single interrupt line. A software-initialise control bit reloads the count from the programmed initial value.

The block has no streaming data path. Every pin is plain control or status, and the block has no back-pressure.

Top module: `quad_pos_counter`

## Requirements
- R1: On synchronous reset (`rst` high at a clock edge), the outputs are cleared:
  - `position` is 0.
  - `flags` is 0.
  - `direction` is 1.
  - `swi_level` is 0.
  - `irq` is 0.
- R2: In full-resolution mode (`res_1x` = 0), every clock edge at which exactly one phase has toggled since the previous edge moves `position` by one. The sequence {A,B} = 00, 10, 11, 01 (A leading B) counts up and sets `direction` to 1. The reverse sequence counts down and sets `direction` to 0.
- R3: In single-resolution mode (`res_1x` = 1), only a rising edge of A counts. With B low it counts up; with B high it counts down. All other transitions leave `position` unchanged.
- R4: In wrap mode (`clamp_mode` = 0), an up count with `position` equal to `max_val` loads 0 and sets flag bit 0 (overflow).
- R5: In wrap mode, a down count with `position` at 0 loads `max_val` and sets flag bit 1 (underflow).
- R6: In clamp mode (`clamp_mode` = 1), `position` holds at `max_val` on further up counts and sets flag bit 0. It holds at `init_val` on further down counts and sets flag bit 1.
- R7: If both phases toggle at the same clock edge, flag bit 4 (phase error) is set and `position` is unchanged.
- R8: A counted edge whose direction differs from the previous counted direction sets flag bit 3 (reversal).
- R9: Flag bit 2 (compare hit) is set whenever `position` is written with a value equal to `cmp_val`.
- R10: A write of 1 to the software-initialise bit (`swi_we` high with `swi_wdata` = 1) loads `init_val` into `position` at that edge. The bit then stays 1 on `swi_level` and counting continues. Every further write of 1 reloads `init_val` again.
- R11: While `count_en` is low, `position`, `direction` and the event flags ignore the phase inputs. Re-enabling does not produce a spurious count.
- R12: Each flag stays set until a one-cycle clear strobe on its `flag_clr` bit. If a set event falls in the same cycle as the clear, the set wins.
- R13: `irq` is the OR of `flags & irq_mask`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| enc_a | input | 1 | Encoder phase A, synchronised |
| enc_b | input | 1 | Encoder phase B, synchronised |
| count_en | input | 1 | Counter enable; low freezes counting |
| res_1x | input | 1 | 1 = count rising A edges only |
| clamp_mode | input | 1 | 1 = saturate at limits, 0 = wrap |
| init_val | input | CNT_W | Initial value and clamp floor |
| max_val | input | CNT_W | Ceiling of the count |
| cmp_val | input | CNT_W | Compare value |
| swi_we | input | 1 | Write strobe for the software-initialise bit |
| swi_wdata | input | 1 | Value written to the software-initialise bit |
| swi_level | output | 1 | Current state of the software-initialise bit |
| flag_clr | input | 5 | Write-one-to-clear strobes, one per flag |
| irq_mask | input | 5 | Per-flag interrupt enables |
| position | output | CNT_W | Position count |
| direction | output | 1 | Direction of the last counted edge, 1 = up |
| flags | output | 5 | Sticky flags: bit0 overflow, bit1 underflow, bit2 compare, bit3 reversal, bit4 phase error |
| irq | output | 1 | Masked OR of the flags |

## Verification
Every internal register in this block shows at the ports no later than the next counted edge.

A stale previous-phase sample shows up at the first clock after the inputs move, either as a count that should not exist or as a false phase error. This is sharpest right after re-enabling. A wrong stored direction stays hidden until the next counted edge, where it sets or suppresses the reversal flag. A boundary decode error changes `position` at the very edge where the limit is hit, so the limit cases are driven in both boundary modes. Flag clear and set collisions are provoked in the same cycle, because a wrong priority there leaves no other trace.

// File: rtl/qpc_pkg.sv
package qpc_pkg;
  localparam int FLAG_N   = 5;
  localparam int FL_OVF   = 0;
  localparam int FL_UNF   = 1;
  localparam int FL_CMP   = 2;
  localparam int FL_DCHG  = 3;
  localparam int FL_PHASE = 4;

  typedef struct packed {
    logic step;       // a qualified edge to count
    logic up;         // direction of that edge
    logic phase_err;  // both phases toggled together
  } qpc_evt_t;
endpackage

// File: rtl/qpc_decode.sv
module qpc_decode
  import qpc_pkg::*;
(
  input  logic     clk,
  input  logic     enc_a,
  input  logic     enc_b,
  input  logic     count_en,
  input  logic     res_1x,
  output qpc_evt_t evt
);
  logic [1:0] prev_ab;
  logic a_chg, b_chg, up_dir, qualified;

  // Previous pair tracks the inputs always, including during reset and while
  // disabled, so re-enabling never sees a stale transition.
  always_ff @(posedge clk) prev_ab <= {enc_a, enc_b};

  always_comb begin
    a_chg     = enc_a ^ prev_ab[1];
    b_chg     = enc_b ^ prev_ab[0];
    // A leading B walks 00 -> 10 -> 11 -> 01: count up.
    up_dir    = a_chg ? (enc_a ^ enc_b) : ~(enc_a ^ enc_b);
    qualified = res_1x ? (a_chg & ~b_chg & enc_a) : (a_chg ^ b_chg);
    evt.step      = count_en & qualified;
    evt.up        = up_dir;
    evt.phase_err = count_en & a_chg & b_chg;
  end
endmodule

// File: rtl/qpc_counter.sv
module qpc_counter
  import qpc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  qpc_evt_t         evt,
  input  logic             clamp_mode,
  input  logic             swi_load,
  input  logic [CNT_W-1:0] init_val,
  input  logic [CNT_W-1:0] max_val,
  input  logic [CNT_W-1:0] cmp_val,
  output logic [CNT_W-1:0] position,
  output logic             direction,
  output logic             ovf_evt,
  output logic             unf_evt,
  output logic             cmp_evt,
  output logic             dchg_evt
);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] ZERO = '0;

  logic [CNT_W-1:0] pos_q, pos_d;
  logic             dir_q, dir_d, upd;

  always_comb begin
    pos_d    = pos_q;
    dir_d    = dir_q;
    upd      = 1'b0;
    ovf_evt  = 1'b0;
    unf_evt  = 1'b0;
    dchg_evt = 1'b0;
    if (swi_load) begin
      pos_d = init_val;
      upd   = 1'b1;
    end else if (evt.step) begin
      upd      = 1'b1;
      dir_d    = evt.up;
      dchg_evt = (evt.up != dir_q);
      if (evt.up) begin
        if (pos_q >= max_val) begin
          ovf_evt = 1'b1;
          pos_d   = clamp_mode ? max_val : ZERO;
        end else begin
          pos_d = pos_q + ONE;
        end
      end else if (clamp_mode) begin
        if (pos_q <= init_val) begin
          unf_evt = 1'b1;
          pos_d   = init_val;
        end else begin
          pos_d = pos_q - ONE;
        end
      end else begin
        if (pos_q == ZERO) begin
          unf_evt = 1'b1;
          pos_d   = max_val;
        end else begin
          pos_d = pos_q - ONE;
        end
      end
    end
    cmp_evt = upd && (pos_d == cmp_val);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q <= ZERO;
      dir_q <= 1'b1;
    end else begin
      pos_q <= pos_d;
      dir_q <= dir_d;
    end
  end

  assign position  = pos_q;
  assign direction = dir_q;

  assert_freeze_R11: assert property (@(posedge clk) disable iff (rst)
    (!evt.step && !swi_load) |=> $stable(pos_q));

  assert_wrap_top_R4: assert property (@(posedge clk) disable iff (rst)
    (!clamp_mode && evt.step && evt.up && !swi_load && pos_q == max_val) |=> (pos_q == ZERO));

  assert_clamp_top_R6: assert property (@(posedge clk) disable iff (rst)
    (clamp_mode && evt.step && evt.up && !swi_load && pos_q >= max_val) |=> (pos_q == $past(max_val)));

  assert_swi_load_R10: assert property (@(posedge clk) disable iff (rst)
    swi_load |=> (pos_q == $past(init_val)));
endmodule

// File: rtl/qpc_flags.sv
module qpc_flags #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_evt,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] mask,
  output logic [N-1:0] flags,
  output logic         irq
);
  logic [N-1:0] flag_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)             flag_q[i] <= 1'b0;
      else if (set_evt[i]) flag_q[i] <= 1'b1;   // set wins over clear
      else if (clr[i])     flag_q[i] <= 1'b0;
    end

    assert_sticky_R12: assert property (@(posedge clk) disable iff (rst)
      (flag_q[i] && !clr[i]) |=> flag_q[i]);
    assert_set_wins_R12: assert property (@(posedge clk) disable iff (rst)
      set_evt[i] |=> flag_q[i]);
  end

  assign flags = flag_q;
  assign irq   = |(flag_q & mask);
endmodule

// File: rtl/quad_pos_counter.sv
module quad_pos_counter
  import qpc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enc_a,
  input  logic             enc_b,
  input  logic             count_en,
  input  logic             res_1x,
  input  logic             clamp_mode,
  input  logic [CNT_W-1:0] init_val,
  input  logic [CNT_W-1:0] max_val,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic             swi_we,
  input  logic             swi_wdata,
  output logic             swi_level,
  input  logic [4:0]       flag_clr,
  input  logic [4:0]       irq_mask,
  output logic [CNT_W-1:0] position,
  output logic             direction,
  output logic [4:0]       flags,
  output logic             irq
);
  qpc_evt_t          evt;
  logic              swi_q, swi_load;
  logic              ovf_evt, unf_evt, cmp_evt, dchg_evt;
  logic [FLAG_N-1:0] flag_set;

  // Level control bit; every write of 1 is a fresh reload request.
  always_ff @(posedge clk) begin
    if (rst)         swi_q <= 1'b0;
    else if (swi_we) swi_q <= swi_wdata;
  end
  assign swi_load  = swi_we & swi_wdata;
  assign swi_level = swi_q;

  qpc_decode u_decode (
    .clk(clk), .enc_a(enc_a), .enc_b(enc_b),
    .count_en(count_en), .res_1x(res_1x), .evt(evt)
  );

  qpc_counter #(.CNT_W(CNT_W)) u_counter (
    .clk(clk), .rst(rst), .evt(evt), .clamp_mode(clamp_mode),
    .swi_load(swi_load), .init_val(init_val), .max_val(max_val),
    .cmp_val(cmp_val), .position(position), .direction(direction),
    .ovf_evt(ovf_evt), .unf_evt(unf_evt), .cmp_evt(cmp_evt),
    .dchg_evt(dchg_evt)
  );

  always_comb begin
    flag_set           = '0;
    flag_set[FL_OVF]   = ovf_evt;
    flag_set[FL_UNF]   = unf_evt;
    flag_set[FL_CMP]   = cmp_evt;
    flag_set[FL_DCHG]  = dchg_evt;
    flag_set[FL_PHASE] = evt.phase_err;
  end

  qpc_flags #(.N(FLAG_N)) u_flags (
    .clk(clk), .rst(rst), .set_evt(flag_set), .clr(flag_clr),
    .mask(irq_mask), .flags(flags), .irq(irq)
  );

  assert_phase_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (count_en && !swi_we && (enc_a != $past(enc_a)) && (enc_b != $past(enc_b)))
      |=> ($stable(position) && flags[FL_PHASE]));
endmodule

// File: tb/quad_pos_counter_test.sv
`timescale 1ns/1ps
module quad_pos_counter_test;
  localparam int W = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, enc_a, enc_b, count_en, res_1x, clamp_mode;
  logic [W-1:0] init_val, max_val, cmp_val;
  logic swi_we, swi_wdata, swi_level;
  logic [4:0] flag_clr, irq_mask, flags;
  logic [W-1:0] position;
  logic direction, irq;

  quad_pos_counter #(.CNT_W(W)) uut (
    .clk(clk), .rst(rst), .enc_a(enc_a), .enc_b(enc_b), .count_en(count_en),
    .res_1x(res_1x), .clamp_mode(clamp_mode), .init_val(init_val),
    .max_val(max_val), .cmp_val(cmp_val), .swi_we(swi_we),
    .swi_wdata(swi_wdata), .swi_level(swi_level), .flag_clr(flag_clr),
    .irq_mask(irq_mask), .position(position), .direction(direction),
    .flags(flags), .irq(irq)
  );

  typedef struct packed {
    logic [W-1:0] pos;
    logic [4:0]   fl;
    logic         dir;
    logic         swi;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    vectors = 0, miscompares = 0;
  logic [4:0] clr_n = '0;
  logic  swi_n = 1'b0;
  bit    done = 1'b0;

  // Driver: applies one phase pair and strobes, pushes the expected result.
  task automatic cyc(input logic [1:0] ab, input logic [W-1:0] p,
                     input logic [4:0] f, input logic d, input logic s,
                     input string tag);
    @(negedge clk);
    enc_a = ab[1]; enc_b = ab[0];
    flag_clr = clr_n; swi_we = swi_n; swi_wdata = swi_n;
    clr_n = '0; swi_n = 1'b0;
    exp_q.push_back('{pos: p, fl: f, dir: d, swi: s});
    tag_q.push_back(tag);
    @(posedge clk);
    #2;
  endtask

  // Monitor: compares the ports one time unit after each edge.
  always @(posedge clk) begin : mon
    exp_t  e;
    string t;
    logic  ei;
    #1;
    if (exp_q.size() > 0) begin
      e  = exp_q.pop_front();
      t  = tag_q.pop_front();
      ei = |(e.fl & irq_mask);   // R13
      vectors++;
      if (position !== e.pos || flags !== e.fl || direction !== e.dir ||
          swi_level !== e.swi || irq !== ei) begin
        miscompares++;
        $display("FAIL %s: pos=%0d flags=%b dir=%b swi=%b irq=%b expected pos=%0d flags=%b dir=%b swi=%b irq=%b",
                 t, position, flags, direction, swi_level, irq,
                 e.pos, e.fl, e.dir, e.swi, ei);
      end
    end
  end

  initial begin : watchdog
    #(8 * 20000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run incomplete, expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; enc_a = 1'b0; enc_b = 1'b0; count_en = 1'b1; res_1x = 1'b0;
    clamp_mode = 1'b0; init_val = 16'd2; max_val = 16'd5; cmp_val = 16'd3;
    swi_we = 1'b0; swi_wdata = 1'b0; flag_clr = '0; irq_mask = 5'b00001;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    cyc(2'b00, 0, 5'b00000, 1, 0, "R1 reset state");

    // Full-resolution decode, wrap mode
    cyc(2'b10, 1, 5'b00000, 1, 0, "R2 up 00->10");
    cyc(2'b11, 2, 5'b00000, 1, 0, "R2 up 10->11");
    cyc(2'b01, 3, 5'b00100, 1, 0, "R9 compare hit at 3");
    cyc(2'b00, 4, 5'b00100, 1, 0, "R2 up 01->00");
    cyc(2'b10, 5, 5'b00100, 1, 0, "R2 up to max");
    cyc(2'b11, 0, 5'b00101, 1, 0, "R4 wrap overflow");
    clr_n = 5'b11111;
    cyc(2'b11, 0, 5'b00000, 1, 0, "R12 clear all");
    cyc(2'b10, 5, 5'b01010, 0, 0, "R5 wrap underflow with R8 reversal");
    cyc(2'b01, 5, 5'b11010, 0, 0, "R7 phase error holds count");
    clr_n = 5'b11111;
    cyc(2'b10, 5, 5'b10000, 0, 0, "R12 set wins over clear");
    clr_n = 5'b11111;
    cyc(2'b10, 5, 5'b00000, 0, 0, "R12 clear");

    // Enable gating
    count_en = 1'b0;
    cyc(2'b11, 5, 5'b00000, 0, 0, "R11 disabled edge ignored");
    cyc(2'b01, 5, 5'b00000, 0, 0, "R11 disabled edge ignored");
    count_en = 1'b1;
    cyc(2'b01, 5, 5'b00000, 0, 0, "R11 no spurious count on enable");

    // Software initialise
    swi_n = 1'b1;
    cyc(2'b01, 2, 5'b00000, 0, 1, "R10 load init");
    cyc(2'b00, 3, 5'b01100, 1, 1, "R10 bit stays set, counting resumes");
    swi_n = 1'b1;
    cyc(2'b00, 2, 5'b01100, 1, 1, "R10 rewrite reloads");

    // Clamp mode
    clamp_mode = 1'b1; clr_n = 5'b11111;
    cyc(2'b10, 3, 5'b00100, 1, 1, "R6 count up in clamp");
    cyc(2'b11, 4, 5'b00100, 1, 1, "R6 count up");
    cyc(2'b01, 5, 5'b00100, 1, 1, "R6 reach ceiling");
    cyc(2'b00, 5, 5'b00101, 1, 1, "R6 hold at ceiling");
    cyc(2'b01, 4, 5'b01101, 0, 1, "R8 reversal in clamp");
    cyc(2'b11, 3, 5'b01101, 0, 1, "R6 count down");
    cyc(2'b10, 2, 5'b01101, 0, 1, "R6 reach floor");
    cyc(2'b00, 2, 5'b01111, 0, 1, "R6 hold at floor");

    // Single-resolution mode
    res_1x = 1'b1; clamp_mode = 1'b0; clr_n = 5'b11111;
    cyc(2'b00, 2, 5'b00000, 0, 1, "R3 idle clear");
    cyc(2'b10, 3, 5'b01100, 1, 1, "R3 rising A, B low, up");
    cyc(2'b11, 3, 5'b01100, 1, 1, "R3 B edge ignored");
    cyc(2'b01, 3, 5'b01100, 1, 1, "R3 falling A ignored");
    cyc(2'b00, 3, 5'b01100, 1, 1, "R3 B edge ignored");
    cyc(2'b01, 3, 5'b01100, 1, 1, "R3 B edge ignored");
    cyc(2'b11, 2, 5'b01100, 0, 1, "R3 rising A, B high, down");

    // Interrupt mask
    irq_mask = 5'b00000;
    cyc(2'b11, 2, 5'b01100, 0, 1, "R13 all masked");
    irq_mask = 5'b01000;
    cyc(2'b11, 2, 5'b01100, 0, 1, "R13 reversal enabled");

    @(negedge clk);
    flag_clr = '0; swi_we = 1'b0;
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule